// File: doc/BRIEF.md
# GPIO Pin Interrupt Router

This block lets software bind any of 32 interrupt channels to any one of 123 general-purpose input pins at run time. Each channel carries its own selector byte (an enable flag plus a pin index) and its own two-bit sense mode. The mode picks one of four kinds of detection: rising edge, falling edge, high level or low level. Every pin is brought into the clock domain by a two-flop synchroniser. The synchronised copy then feeds edge and level detection, and a hit latches into a per-channel status bit. Each channel presents an active-high level request to a parent interrupt controller.

Software reaches the block through a single-cycle register port with word addressing, separate read and write strobes, 32-bit write data and registered read data. To service a request, software reads the status word and then writes it back with zeros in the positions it wants to clear.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads as zero, and `irqOut` is all zero. Every channel therefore starts disabled, in rising-edge mode, with status clear.
- R2: The register map uses word addresses. The status word is at 8. The sense word for channels 0 to 15 is at 9, and the sense word for channels 16 to 31 is at 10. The selector words are at 12 to 19, with channel n in word 12+n/4, bits [8*(n%4)+7 : 8*(n%4)]. A write to a mapped word is read back unchanged. Any other word reads zero. Read data is registered on the rising edge that samples `regRd` and holds until the next read.
- R3: Within a selector byte, bit 7 enables the channel and bits 6:0 give the pin index. A channel whose enable is clear never sets its status bit and never raises its request.
- R4: A pin index of 123 or above means no source, and that channel never fires, in any mode. Index 122 is a valid pin.
- R5: Channel c's sense field sits at bits [2*(c%16)+1 : 2*(c%16)] of its sense word. Sense code 0 sets status on a low-to-high transition of the selected pin, and the bit stays set after the pin returns low.
- R6: Sense code 1 sets status on a high-to-low transition of the selected pin, and the bit stays set afterwards.
- R7: Sense code 2 sets status while the pin is high, and sense code 3 sets it while the pin is low. A clear has no lasting effect while the active level persists.
- R8: A write to the status word clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R9: An edge detected in the same cycle as a clear of that channel leaves the status bit set.
- R10: A pin change becomes visible in status and `irqOut` on the third rising clock edge after it, and not on the second. This delay comes from two synchroniser flops plus the status register.
- R11: `irqOut[c]` is high exactly when channel c's status is set and the channel is enabled. Several channels may select the same pin, and each one uses its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 123 | Asynchronous general-purpose pin inputs |
| regAddr | input | 6 | Word address of the register access |
| regWr | input | 1 | Write strobe, one cycle |
| regRd | input | 1 | Read strobe, one cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| irqOut | output | 32 | Active-high request per channel to the parent controller |

## Verification
Every channel is swept in turn. Each channel gets its own pin and the sense mode c%4, and is driven through a high, low, high, low pin sequence, with a status clear after every step. This pattern separates the four detection kinds: a level mode survives a clear while its level is active, an edge mode does not, and each edge mode responds to only one transition. It also catches a wrong byte lane or sense-field placement, because any other channel lighting up shows as a mismatch in the full request vector.

Each step is sampled after two edges and after three, which pins down the pipeline depth exactly. Directed cases cover the rest:
- a disabled selector;
- the indices 122, 123 and 127;
- two channels sharing one pin;
- a clear that writes ones;
- an edge arriving in the very cycle of a clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int CHANNELS  = 32;
  localparam int LANES     = 4;
  localparam int SEL_REGS  = CHANNELS / LANES;
  localparam int SEL_IDX_W = $clog2(SEL_REGS);
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int HALF_CH   = CHANNELS / 2;

  localparam logic [ADDR_W-1:0] WORD_STATUS   = 6'd8;
  localparam logic [ADDR_W-1:0] WORD_SENSE_LO = 6'd9;
  localparam logic [ADDR_W-1:0] WORD_SENSE_HI = 6'd10;
  localparam logic [ADDR_W-1:0] WORD_SEL_BASE = 6'd12;

  localparam logic [1:0] SENSE_RISE = 2'd0;
  localparam logic [1:0] SENSE_FALL = 2'd1;
  localparam logic [1:0] SENSE_HIGH = 2'd2;
  localparam logic [1:0] SENSE_LOW  = 2'd3;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_SENSE_LO, RD_SENSE_HI, RD_SEL
  } rdSrc_e;

  typedef struct packed {
    logic                 wrStatus;
    logic                 wrSenseLo;
    logic                 wrSenseHi;
    logic                 wrSel;
    logic [SEL_IDX_W-1:0] selIdx;
    logic                 rdEn;
    rdSrc_e               rdSrc;
  } regStb_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output regStb_t           stb
);
  logic [ADDR_W-1:0] selOffset;
  logic              inSelRange;
  rdSrc_e            target;

  assign selOffset  = regAddr - WORD_SEL_BASE;
  assign inSelRange = (regAddr >= WORD_SEL_BASE) &&
                      (regAddr <  WORD_SEL_BASE + ADDR_W'(SEL_REGS));

  always_comb begin
    if (inSelRange)                   target = RD_SEL;
    else if (regAddr == WORD_STATUS)   target = RD_STATUS;
    else if (regAddr == WORD_SENSE_LO) target = RD_SENSE_LO;
    else if (regAddr == WORD_SENSE_HI) target = RD_SENSE_HI;
    else                               target = RD_NONE;
  end

  always_comb begin
    stb.wrStatus  = regWr && (target == RD_STATUS);
    stb.wrSenseLo = regWr && (target == RD_SENSE_LO);
    stb.wrSenseHi = regWr && (target == RD_SENSE_HI);
    stb.wrSel     = regWr && (target == RD_SEL);
    stb.selIdx    = selOffset[SEL_IDX_W-1:0];
    stb.rdEn      = regRd;
    stb.rdSrc     = target;
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrStatus, stb.wrSenseLo, stb.wrSenseHi, stb.wrSel})); // R2
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 123
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  regStb_t             stb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic [CHANNELS-1:0] irqOut
);
  localparam int IDX_W = $clog2(NUM_PINS);
  localparam int PAD_W = 1 << IDX_W;

  logic [NUM_PINS-1:0] pinMeta, pinSync, pinPrev;
  logic [PAD_W-1:0]    padSync, padPrev;

  logic [SEL_REGS-1:0][DATA_W-1:0] selReg;
  logic [2*CHANNELS-1:0]           senseReg;
  logic [CHANNELS-1:0]             status;

  logic [CHANNELS-1:0]       chEn, chValid, chCur, chPrv, chHit;
  logic [CHANNELS-1:0][1:0]  chMode;

  // two-flop synchroniser plus one-cycle history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinMeta <= '0;
      pinSync <= '0;
      pinPrev <= '0;
    end else begin
      pinMeta <= pinIn;
      pinSync <= pinMeta;
      pinPrev <= pinSync;
    end
  end

  assign padSync = PAD_W'(pinSync);
  assign padPrev = PAD_W'(pinPrev);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [7:0]       selByte;
    logic [IDX_W-1:0] pinIdx;
    logic             rawHit;

    assign selByte     = selReg[ch / LANES][8*(ch % LANES) +: 8];
    assign pinIdx      = selByte[IDX_W-1:0];
    assign chEn[ch]    = selByte[7];
    assign chValid[ch] = (32'(pinIdx) < NUM_PINS);
    assign chCur[ch]   = padSync[pinIdx];
    assign chPrv[ch]   = padPrev[pinIdx];
    assign chMode[ch]  = senseReg[2*ch +: 2];

    always_comb begin
      case (chMode[ch])
        SENSE_RISE: rawHit =  chCur[ch] && !chPrv[ch];
        SENSE_FALL: rawHit = !chCur[ch] &&  chPrv[ch];
        SENSE_HIGH: rawHit =  chCur[ch];
        default:    rawHit = !chCur[ch];
      endcase
    end

    assign chHit[ch] = chEn[ch] && chValid[ch] && rawHit;

    AST_NO_SILENT_SET: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[ch]) |-> $past(chEn[ch] && chValid[ch])); // R3
    AST_BAD_INDEX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (!chValid[ch] && !status[ch]) |=> !status[ch]); // R4
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && chValid[ch] && chMode[ch] == SENSE_RISE && chCur[ch] && !chPrv[ch])
      |=> status[ch]); // R5
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (chEn[ch] && chValid[ch] && chMode[ch] == SENSE_HIGH && chCur[ch])
      |=> status[ch]); // R7
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(status[ch]) |-> $past(stb.wrStatus && !wdata[ch])); // R8
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      senseReg <= '0;
      status   <= '0;
    end else begin
      if (stb.wrSel)     selReg[stb.selIdx]         <= wdata;
      if (stb.wrSenseLo) senseReg[HALF_CH*2-1:0]    <= wdata;
      if (stb.wrSenseHi) senseReg[CHANNELS*2-1:HALF_CH*2] <= wdata;
      status <= (stb.wrStatus ? (status & wdata) : status) | chHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (stb.rdEn) begin
      case (stb.rdSrc)
        RD_STATUS:   rdata <= status;
        RD_SENSE_LO: rdata <= senseReg[HALF_CH*2-1:0];
        RD_SENSE_HI: rdata <= senseReg[CHANNELS*2-1:HALF_CH*2];
        RD_SEL:      rdata <= selReg[stb.selIdx];
        default:     rdata <= '0;
      endcase
    end
  end

  assign irqOut = status & chEn;

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(rdata)); // R2
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 123
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWr,
  input  logic                regRd,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  output logic [CHANNELS-1:0] irqOut
);
  regStb_t stb;

  gpio_irq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .regRd   (regRd),
    .stb     (stb)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .stb    (stb),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 123;
  localparam int NCH  = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NPIN-1:0] pins = '0;
  logic [5:0]      addr = '0;
  logic            wr = 1'b0;
  logic            rd = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [31:0]     irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] selSh [8];
  logic [63:0] senseSh = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pins), .regAddr(addr), .regWr(wr),
    .regRd(rd), .regWdata(wdata), .regRdata(rdata), .irqOut(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(posedge clk);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk); pins[p] = v;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic programChan(input int ch, input int pin, input logic en, input logic [1:0] mode);
    selSh[ch/4][8*(ch%4) +: 8] = {en, 7'(pin)};
    regWrite(6'(12 + ch/4), selSh[ch/4]);
    senseSh[2*ch +: 2] = mode;
    if (ch < 16) regWrite(6'd9, senseSh[31:0]);
    else         regWrite(6'd10, senseSh[63:32]);
  endtask

  function automatic logic levelOn(input logic [1:0] mode, input logic v);
    return (mode == 2'd2) ? v : (mode == 2'd3) ? !v : 1'b0;
  endfunction

  function automatic logic edgeHit(input logic [1:0] mode, input logic pv, input logic cv);
    return (mode == 2'd0) ? (cv && !pv) : (mode == 2'd1) ? (!cv && pv) : 1'b0;
  endfunction

  function automatic string reqFor(input logic [1:0] mode);
    return (mode == 2'd0) ? "R5" : (mode == 2'd1) ? "R6" : "R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    for (int i = 0; i < 8; i++) selSh[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    chk("R1 irq", irq, 32'h0);
    for (int w = 8; w < 20; w++) begin
      regRead(6'(w), rv);
      chk("R1 reg", rv, 32'h0);
    end

    // R2: readback and unmapped words
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pat;
      pat = (32'(i + 1) * 32'h0103_0507) & 32'h7F7F_7F7F;
      regWrite(6'(12 + i), pat);
      regRead(6'(12 + i), rv);
      chk("R2 selector", rv, pat);
    end
    regWrite(6'd9, 32'hA5C3_0F96);
    regWrite(6'd10, 32'h5A3C_F069);
    regRead(6'd9, rv);  chk("R2 sense lo", rv, 32'hA5C3_0F96);
    regRead(6'd10, rv); chk("R2 sense hi", rv, 32'h5A3C_F069);
    regRead(6'd11, rv); chk("R2 unmapped", rv, 32'h0);
    regRead(6'd20, rv); chk("R2 unmapped", rv, 32'h0);
    regRead(6'd0, rv);  chk("R2 unmapped", rv, 32'h0);
    for (int i = 0; i < 8; i++) regWrite(6'(12 + i), 32'h0);
    regWrite(6'd9, 32'h0);
    regWrite(6'd10, 32'h0);
    regWrite(6'd8, 32'h0);
    chk("R3 quiet", irq, 32'h0);

    // sweep every channel, mode ch%4, through a pin sequence
    for (int ch = 0; ch < NCH; ch++) begin
      int pin;
      logic [1:0] mode;
      logic st, pv;
      pin  = (ch * 37 + 5) % NPIN;
      mode = 2'(ch % 4);
      programChan(ch, pin, 1'b1, mode);
      waitCycles(4);
      regWrite(6'd8, 32'h0);
      st = levelOn(mode, 1'b0);
      chk(reqFor(mode), irq, 32'(st) << ch);
      pv = 1'b0;
      for (int step = 0; step < 4; step++) begin
        logic v;
        v = (step % 2 == 0);
        setPin(pin, v);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 early", irq, 32'(st) << ch);
        @(posedge clk);
        @(negedge clk);
        st = st | edgeHit(mode, pv, v) | levelOn(mode, v);
        chk(reqFor(mode), irq, 32'(st) << ch);
        regWrite(6'd8, 32'h0);
        st = levelOn(mode, v);
        chk((mode >= 2) ? "R7 clear" : "R8 clear", irq, 32'(st) << ch);
        pv = v;
      end
      programChan(ch, 0, 1'b0, 2'd0);
      regWrite(6'd8, 32'h0);
      chk("R3 disable", irq, 32'h0);
    end

    // R3: disabled channel in low-level mode with pin low
    programChan(3, 10, 1'b0, 2'd3);
    waitCycles(5);
    chk("R3 disabled irq", irq, 32'h0);
    regRead(6'd8, rv);
    chk("R3 disabled status", rv, 32'h0);
    programChan(3, 0, 1'b0, 2'd0);

    // R4: out-of-range indices, and the last valid one
    programChan(5, 123, 1'b1, 2'd3);
    waitCycles(5);
    chk("R4 index 123", irq, 32'h0);
    programChan(5, 127, 1'b1, 2'd3);
    waitCycles(5);
    chk("R4 index 127", irq, 32'h0);
    regRead(6'd8, rv);
    chk("R4 status", rv, 32'h0);
    programChan(5, 122, 1'b1, 2'd3);
    waitCycles(5);
    chk("R4 index 122", irq, 32'h0000_0020);
    programChan(5, 0, 1'b0, 2'd0);
    regWrite(6'd8, 32'h0);

    // R11: two channels on one pin with different modes
    programChan(7, 50, 1'b1, 2'd0);
    programChan(20, 50, 1'b1, 2'd1);
    waitCycles(3);
    regWrite(6'd8, 32'h0);
    setPin(50, 1'b1);
    waitCycles(3);
    chk("R11 rise only", irq, 32'h0000_0080);
    setPin(50, 1'b0);
    waitCycles(3);
    chk("R11 both", irq, 32'h0010_0080);
    // R8: ones leave bits untouched
    regWrite(6'd8, ~32'h0000_0080);
    regRead(6'd8, rv);
    chk("R8 partial clear", rv, 32'h0010_0000);
    chk("R8 irq", irq, 32'h0010_0000);
    // R11: disabling masks a latched status
    programChan(20, 50, 1'b0, 2'd1);
    chk("R11 masked", irq, 32'h0);
    programChan(7, 0, 1'b0, 2'd0);
    programChan(20, 0, 1'b0, 2'd0);
    regWrite(6'd8, 32'h0);

    // R9: edge in the same cycle as a clear
    programChan(0, 3, 1'b1, 2'd0);
    setPin(3, 1'b1);
    waitCycles(3);
    chk("R9 first edge", irq, 32'h1);
    setPin(3, 1'b0);
    waitCycles(3);
    setPin(3, 1'b1);
    repeat (2) @(posedge clk);
    regWrite(6'd8, 32'h0);
    chk("R9 coincident", irq, 32'h1);
    regWrite(6'd8, 32'h0);
    chk("R9 later clear", irq, 32'h0);
    setPin(3, 1'b0);
    programChan(0, 0, 1'b0, 2'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule